// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Controller

This block sits between a clock generator's dividers and its output buffers. Three source clocks come in: the CPU clock, the 66 MHz clock and the PCI clock. The block fans each one out to its own group of outputs. Two active-low stop pins, one for PCI and one for CPU, can park outputs. Each output's register bits decide whether that output obeys its stop pin and whether it is enabled at all. Parking and restart only happen at points in the clock waveform where they cannot cut a pulse short.

Each stop pin is passed through a two-flop synchronizer in every clock domain it controls. Single-ended outputs are gated by a flop clocked on the falling edge of the source, so the gate only changes while the source is low. A CPU differential pair has two stopped states, selected by a configuration bit. In the first, the true leg is held high and driven while the complement is released. In the second, both legs are released and low. For each pair the block also produces drive-enable signals for the output buffers. The register inputs are static configuration and are expected to change only while the affected outputs are settled.

Top module: `clkstop_top`

## Requirements
- R1: While `rst_n` is low, every PCI, free-run-capable PCI and 66 MHz output is low. Every CPU complement is low with its drive enable 0. Every CPU true output is parked in the state selected by `cpu_park_float`.
- R2: A PCI output with its enable bit at 1 toggles while `pci_stop_n` is high. It stays low while `pci_stop_n` is low.
- R3: A free-run-capable PCI output stops only when `pci_stop_n` is low and its `pcif_freerun` bit is 0. With the bit at 1 it keeps toggling whatever the pin does.
- R4: A CPU pair stops only when `cpu_stop_n` is low and its `cpu_allow_run` bit is 0. With the bit at 1 the pair keeps toggling.
- R5: A 66 MHz output stops only when `cpu_stop_n` is low and its `g66_stop_en` bit is 1. Every other combination leaves it toggling.
- R6: A stopped CPU pair with `cpu_park_float`=0 holds the true output at 1 with its drive enable 1, and the complement at 0 with its drive enable 0. With `cpu_park_float`=1, both outputs are 0 and both drive enables are 0. A running pair has both drive enables at 1.
- R7: After `cpu_stop_n` rises, a stopped CPU pair resumes toggling within 2 to 6 CPU clock periods.
- R8: An output whose enable bit is 0 stays off regardless of the stop pins. For a CPU pair, "off" means the stopped state of R6.
- R9: No gated output ever shows a high pulse shorter than the high half-period of its source clock, whether it is stopping or restarting.
- R10: A single-ended output's gate takes the value computed from the synchronized stop at the falling edge of its source. The output therefore parks and restarts only while that source is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU source clock |
| clk_66 | input | 1 | 66 MHz source clock |
| clk_pci | input | 1 | PCI source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low CPU stop pin (asynchronous) |
| pci_stop_n | input | 1 | Active-low PCI stop pin (asynchronous) |
| cpu_park_float | input | 1 | Stopped CPU state: 0 true driven high, 1 both undriven |
| cpu_allow_run | input | N_CPU | Per pair: 1 ignores `cpu_stop_n` |
| cpu_oe | input | N_CPU | Per pair enable, 1 enabled |
| pci_oe | input | N_PCI | Per PCI output enable |
| pcif_freerun | input | N_PCIF | Per free-run-capable PCI output: 1 ignores `pci_stop_n` |
| pcif_oe | input | N_PCIF | Per free-run-capable PCI output enable |
| g66_stop_en | input | N_66 | Per 66 MHz output: 1 obeys `cpu_stop_n` |
| g66_oe | input | N_66 | Per 66 MHz output enable |
| cpu_t | output | N_CPU | CPU true outputs |
| cpu_c | output | N_CPU | CPU complement outputs |
| cpu_t_drv | output | N_CPU | Drive enable for true outputs |
| cpu_c_drv | output | N_CPU | Drive enable for complement outputs |
| pci_clk_o | output | N_PCI | Gated PCI outputs |
| pcif_clk_o | output | N_PCIF | Gated free-run-capable PCI outputs |
| g66_clk_o | output | N_66 | Gated 66 MHz outputs |

## Verification
Stop-pin and register combinations are drawn at random. Directed cases are added for the polarity traps: the CPU allow bit keeps a pair running when it is 1, while the 66 MHz bit enables stopping when it is 1. If one of these polarities were inverted, outputs would stop or run against the pin.

Pulse monitors watch every output across each stop and restart. A gate updated on the rising edge, or a park that drops the true leg at the wrong edge, would leave a pulse shorter than half a period.

Restart latency after CPU-stop release is counted in both park modes. A missing synchronizer stage or a gate that never reopens would push the count out of the 2 to 6 period window. The park-level checks cover the drive-enable polarity, which an inverted mode select would swap.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  typedef enum logic {
    PARK_T_HIGH = 1'b0,
    PARK_FLOAT  = 1'b1
  } park_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Stop-pin synchronizer into one clock domain; resets to the "stopped" level.
module clkstop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// Single-ended gate: enable captured at the falling edge, so it only moves while clk is low.
module clkstop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gclk
);
  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run;
  end

  assign gclk = clk & en_q;

  // R2 / R8: a run request that was low at the last falling edge keeps this high phase empty
  p_gate_park_r2: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(run) |-> !gclk);

  // R10: a run request seen at the last falling edge (out of reset) yields a full high phase
  p_gate_run_r10: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(run) && $past(rst_n)) |-> gclk);
endmodule

// File: rtl/clkstop_cpu_pair.sv
`timescale 1ns/1ps
// Differential pair gate. The true leg changes at the edge matching its park level:
// rising edge when it parks high, falling edge when it floats low. The complement
// always changes at the rising edge, where it is already low.
module clkstop_cpu_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic park_float,
  output logic t,
  output logic c,
  output logic t_drv,
  output logic c_drv
);
  logic run_pos_q;
  logic run_neg_q;
  logic run_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_pos_q <= 1'b0;
    else        run_pos_q <= run;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_neg_q <= 1'b0;
    else        run_neg_q <= run;
  end

  assign run_t = park_float ? run_neg_q : run_pos_q;
  assign t     = run_t ? clk : ~park_float;
  assign c     = run_pos_q ? ~clk : 1'b0;
  assign t_drv = run_t | ~park_float;
  assign c_drv = run_pos_q;

  // R6: an undriven true leg sits low
  p_cpu_float_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !t_drv |-> !t);

  // R6: an undriven complement sits low
  p_cpu_comp_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !c_drv |-> !c);

  // R6: in the drive-high park mode the true leg is never released
  p_cpu_true_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !park_float |-> t_drv);

  // R7: a run request seen at the previous rising edge has the complement driven
  p_cpu_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(rst_n)) |-> c_drv);
endmodule

// File: rtl/clkstop_top.sv
`timescale 1ns/1ps
module clkstop_top #(
  parameter int unsigned N_CPU  = 3,
  parameter int unsigned N_PCI  = 7,
  parameter int unsigned N_PCIF = 3,
  parameter int unsigned N_66   = 6
) (
  input  logic              clk_cpu,
  input  logic              clk_66,
  input  logic              clk_pci,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              cpu_park_float,
  input  logic [N_CPU-1:0]  cpu_allow_run,
  input  logic [N_CPU-1:0]  cpu_oe,
  input  logic [N_PCI-1:0]  pci_oe,
  input  logic [N_PCIF-1:0] pcif_freerun,
  input  logic [N_PCIF-1:0] pcif_oe,
  input  logic [N_66-1:0]   g66_stop_en,
  input  logic [N_66-1:0]   g66_oe,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_t_drv,
  output logic [N_CPU-1:0]  cpu_c_drv,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_PCIF-1:0] pcif_clk_o,
  output logic [N_66-1:0]   g66_clk_o
);
  import clkstop_pkg::*;

  park_e park_mode;
  logic  cpu_go_cpu;   // cpu_stop_n in the CPU domain (1 = not stopping)
  logic  cpu_go_66;    // cpu_stop_n in the 66 MHz domain
  logic  pci_go_pci;   // pci_stop_n in the PCI domain

  assign park_mode = park_e'(cpu_park_float);

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_cpu (
    .clk(clk_cpu), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_go_cpu));
  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_66 (
    .clk(clk_66), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_go_66));
  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync_pci (
    .clk(clk_pci), .rst_n(rst_n), .d(pci_stop_n), .q(pci_go_pci));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic run;
    assign run = cpu_oe[i] & (cpu_go_cpu | cpu_allow_run[i]);
    clkstop_cpu_pair u_pair (
      .clk(clk_cpu), .rst_n(rst_n), .run(run),
      .park_float(park_mode == PARK_FLOAT),
      .t(cpu_t[i]), .c(cpu_c[i]), .t_drv(cpu_t_drv[i]), .c_drv(cpu_c_drv[i]));
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    logic run;
    assign run = pci_oe[i] & pci_go_pci;
    clkstop_gate u_gate (
      .clk(clk_pci), .rst_n(rst_n), .run(run), .gclk(pci_clk_o[i]));
  end

  for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
    logic run;
    assign run = pcif_oe[i] & (pci_go_pci | pcif_freerun[i]);
    clkstop_gate u_gate (
      .clk(clk_pci), .rst_n(rst_n), .run(run), .gclk(pcif_clk_o[i]));
  end

  for (genvar i = 0; i < N_66; i++) begin : g_66
    logic run;
    assign run = g66_oe[i] & (cpu_go_66 | ~g66_stop_en[i]);
    clkstop_gate u_gate (
      .clk(clk_66), .rst_n(rst_n), .run(run), .gclk(g66_clk_o[i]));
  end
endmodule

// File: tb/clkstop_top_bench.sv
`timescale 1ns/1ps
// Counts rising edges of one output and flags high pulses shorter than HALF_NS.
module clkstop_watch #(
  parameter int HALF_NS = 2
) (
  input  logic sig,
  output int   rises,
  output int   runts
);
  realtime t_rise;
  initial begin
    rises  = 0;
    runts  = 0;
    t_rise = 0.0;
  end
  always @(posedge sig) begin
    t_rise = $realtime;
    rises  = rises + 1;
  end
  always @(negedge sig) begin
    if (rises > 0 && ($realtime - t_rise) < (HALF_NS - 0.01)) begin
      runts = runts + 1;
      $display("FAIL R9 runt high pulse at %0t: actual %0.3f ns expected >= %0d ns",
               $realtime, $realtime - t_rise, HALF_NS);
    end
  end
endmodule

module clkstop_top_bench;
  localparam int NC = 3, NP = 7, NF = 3, N6 = 6;

  logic clk_cpu = 1'b0, clk_66 = 1'b0, clk_pci = 1'b0, rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, cpu_park_float = 1'b0;
  logic [NC-1:0] cpu_allow_run = '0, cpu_oe = '1;
  logic [NP-1:0] pci_oe = '1;
  logic [NF-1:0] pcif_freerun = '0, pcif_oe = '1;
  logic [N6-1:0] g66_stop_en = '0, g66_oe = '1;
  logic [NC-1:0] cpu_t, cpu_c, cpu_t_drv, cpu_c_drv;
  logic [NP-1:0] pci_clk_o;
  logic [NF-1:0] pcif_clk_o;
  logic [N6-1:0] g66_clk_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // 250 MHz CPU source, 125 MHz and 62.5 MHz stand-ins for the slower groups
  initial forever #2 clk_cpu = ~clk_cpu;
  initial forever #4 clk_66  = ~clk_66;
  initial forever #8 clk_pci = ~clk_pci;

  clkstop_top #(.N_CPU(NC), .N_PCI(NP), .N_PCIF(NF), .N_66(N6)) u_clkstop_top (
    .clk_cpu(clk_cpu), .clk_66(clk_66), .clk_pci(clk_pci), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .cpu_park_float(cpu_park_float),
    .cpu_allow_run(cpu_allow_run), .cpu_oe(cpu_oe), .pci_oe(pci_oe),
    .pcif_freerun(pcif_freerun), .pcif_oe(pcif_oe), .g66_stop_en(g66_stop_en),
    .g66_oe(g66_oe), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_t_drv(cpu_t_drv),
    .cpu_c_drv(cpu_c_drv), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o),
    .g66_clk_o(g66_clk_o));

  int rt_r[NC], rt_x[NC], rp_r[NP], rp_x[NP], rf_r[NF], rf_x[NF], r6_r[N6], r6_x[N6];
  for (genvar i = 0; i < NC; i++) begin : g_wc
    clkstop_watch #(.HALF_NS(2)) u_w (.sig(cpu_t[i]), .rises(rt_r[i]), .runts(rt_x[i]));
  end
  for (genvar i = 0; i < NP; i++) begin : g_wp
    clkstop_watch #(.HALF_NS(8)) u_w (.sig(pci_clk_o[i]), .rises(rp_r[i]), .runts(rp_x[i]));
  end
  for (genvar i = 0; i < NF; i++) begin : g_wf
    clkstop_watch #(.HALF_NS(8)) u_w (.sig(pcif_clk_o[i]), .rises(rf_r[i]), .runts(rf_x[i]));
  end
  for (genvar i = 0; i < N6; i++) begin : g_w6
    clkstop_watch #(.HALF_NS(4)) u_w (.sig(g66_clk_o[i]), .rises(r6_r[i]), .runts(r6_x[i]));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected run state of each output, straight from the requirements
  function automatic bit exp_pci(input int i);
    return pci_oe[i] & pci_stop_n;                                  // R2, R8
  endfunction
  function automatic bit exp_pcif(input int i);
    return pcif_oe[i] & (pci_stop_n | pcif_freerun[i]);             // R3, R8
  endfunction
  function automatic bit exp_cpu(input int i);
    return cpu_oe[i] & (cpu_stop_n | cpu_allow_run[i]);             // R4, R8
  endfunction
  function automatic bit exp_66(input int i);
    return g66_oe[i] & ~(~cpu_stop_n & g66_stop_en[i]);             // R5, R8
  endfunction

  // Settle, then count edges over a 128 ns window and check run/stop and park levels
  task automatic window(input string tag);
    int bt[NC], bp[NP], bf[NF], b6[N6];
    #160;
    for (int i = 0; i < NC; i++) bt[i] = rt_r[i];
    for (int i = 0; i < NP; i++) bp[i] = rp_r[i];
    for (int i = 0; i < NF; i++) bf[i] = rf_r[i];
    for (int i = 0; i < N6; i++) b6[i] = r6_r[i];
    #128;
    #0.5;
    for (int i = 0; i < NP; i++) begin
      int d = rp_r[i] - bp[i];
      chk(exp_pci(i) ? (d >= 6) : (d == 0), "R2", {tag, " pci toggles"}, d, exp_pci(i) ? 8 : 0);
    end
    for (int i = 0; i < NF; i++) begin
      int d = rf_r[i] - bf[i];
      chk(exp_pcif(i) ? (d >= 6) : (d == 0), "R3", {tag, " pcif toggles"}, d, exp_pcif(i) ? 8 : 0);
    end
    for (int i = 0; i < N6; i++) begin
      int d = r6_r[i] - b6[i];
      chk(exp_66(i) ? (d >= 12) : (d == 0), "R5", {tag, " 66 toggles"}, d, exp_66(i) ? 16 : 0);
    end
    for (int i = 0; i < NC; i++) begin
      int d = rt_r[i] - bt[i];
      int act, exp;
      chk(exp_cpu(i) ? (d >= 28) : (d == 0), "R4", {tag, " cpu toggles"}, d, exp_cpu(i) ? 32 : 0);
      act = {cpu_t_drv[i], cpu_c_drv[i]};
      exp = exp_cpu(i) ? 3 : {~cpu_park_float, 1'b0};
      if (!exp_cpu(i)) begin
        act = {act[1:0], cpu_t[i], cpu_c[i]};
        exp = {exp[1:0], ~cpu_park_float, 1'b0};
      end
      chk(act == exp, "R6", {tag, " cpu drive/park"}, act, exp);
    end
  endtask

  task automatic apply(input bit cs, input bit ps, input bit pf);
    @(posedge clk_pci);
    #1;
    cpu_stop_n = cs;
    pci_stop_n = ps;
    cpu_park_float = pf;
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R1: reset state
    #21;
    chk(pci_clk_o == '0 && pcif_clk_o == '0, "R1", "pci outputs in reset",
        {pci_clk_o, pcif_clk_o}, 0);
    chk(g66_clk_o == '0, "R1", "66 outputs in reset", g66_clk_o, 0);
    chk(cpu_c_drv == '0 && cpu_c == '0, "R1", "cpu complement in reset", {cpu_c_drv, cpu_c}, 0);
    chk(cpu_t == '1 && cpu_t_drv == '1, "R1", "cpu true parked high", {cpu_t, cpu_t_drv}, 63);
    @(posedge clk_pci);
    #1 rst_n = 1'b1;

    // Directed: all running, no stops
    window("all-run");
    // R2/R3: PCI stop with one free-run bit set
    pcif_freerun = 3'b010;
    apply(1'b1, 1'b0, 1'b0);
    window("pci-stop freerun1");
    // R4/R5 polarity: allow bit and 66 stop-enable bit
    cpu_allow_run = 3'b100;
    g66_stop_en = 6'b001111;
    apply(1'b0, 1'b1, 1'b0);
    window("cpu-stop park-high");
    apply(1'b0, 1'b1, 1'b1);
    window("cpu-stop park-float");
    // R8: enables off with stops released
    cpu_oe = '0; pci_oe = '0; pcif_oe = '0; g66_oe = '0;
    apply(1'b1, 1'b1, 1'b0);
    window("all-disabled");
    cpu_oe = '1; pci_oe = '1; pcif_oe = '1; g66_oe = '1;
    cpu_allow_run = '0;

    // R7: restart latency, drive-high park mode (true leg resumes with a fall)
    apply(1'b0, 1'b1, 1'b0);
    #160;
    @(posedge clk_cpu);
    #1 cpu_stop_n = 1'b1;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_cpu);
      #0.5;
      n++;
      if (cpu_t[0] == 1'b0) break;
    end
    chk(n >= 2 && n <= 6, "R7", "restart periods park-high", n, 4);
    // R7: restart latency, float park mode (true leg resumes with a rise)
    apply(1'b0, 1'b1, 1'b1);
    #160;
    @(posedge clk_cpu);
    #1 cpu_stop_n = 1'b1;
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_cpu);
      #0.5;
      n++;
      if (cpu_t[0] == 1'b1) break;
    end
    chk(n >= 2 && n <= 6, "R7", "restart periods park-float", n, 4);

    // Constrained random configurations
    for (int it = 0; it < 20; it++) begin
      cpu_allow_run = NC'($urandom);
      cpu_oe        = NC'($urandom | $urandom);
      pci_oe        = NP'($urandom | $urandom);
      pcif_freerun  = NF'($urandom);
      pcif_oe       = NF'($urandom | $urandom);
      g66_stop_en   = N6'($urandom);
      g66_oe        = N6'($urandom | $urandom);
      apply(1'($urandom), 1'($urandom), 1'($urandom));
      window("random");
    end

    // R9 / R10: no short pulse on any output across all stops and restarts
    begin
      int tot = 0;
      for (int i = 0; i < NC; i++) tot += rt_x[i];
      for (int i = 0; i < NP; i++) tot += rp_x[i];
      for (int i = 0; i < NF; i++) tot += rf_x[i];
      for (int i = 0; i < N6; i++) tot += r6_x[i];
      chk(tot == 0, "R9", "runt pulses total", tot, 0);
      chk(tot == 0, "R10", "gate moves only while source low", tot, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule